// File: doc/BRIEF.md
# Dual-Channel PWM and Delta-Sigma Generator

This block drives two output pins from one shared input clock. Each channel has its own mode, a range value M and a data value N, all loaded through a small write port. A channel can stay idle, run as a counter-and-compare pulse-width modulator, or act as a first-order delta-sigma modulator. In delta-sigma mode it places N high cycles as evenly as possible in every M cycles, which gives a dense bitstream that a simple RC low-pass filter turns into an analog level.

In PWM mode the range sets the period in input clock cycles and the data value sets how many cycles at the start of each period the pin is high. Values written while a channel runs PWM are held back until the current period ends, so a period is never cut or stretched halfway. Delta-sigma mode uses the live register values on every cycle.

Top module: `pwm_dual_ds`

## Requirements
- R1: After reset every output pin is low, every channel mode is 0 (idle) and every range and data value is 0.
- R2: A write with wrEn high stores wrData into the channel chosen by wrChan: wrSel 0 sets the mode (wrData[1:0]), 1 sets the range M, 2 sets the data N, and 3 changes nothing. A stored value is used from the clock edge after the write.
- R3: A channel whose mode is 0 or 3 drives its pin low and holds its period counter and accumulator at zero, so the next start begins a fresh period or a fresh accumulation.
- R4: In mode 1 (PWM) the pin is high for the first N cycles of every M-cycle period and low for the rest; the pin is registered and follows the mode by one clock.
- R5: In PWM mode a data value greater than or equal to the range keeps the pin high; a data value of 0 keeps it low.
- R6: In PWM mode new range and data values take effect only at the next period boundary; when a channel enters PWM from another mode the current values are loaded at once and a new period starts.
- R7: In mode 2 (delta-sigma) an accumulator adds N each cycle; when the sum reaches M or more, M is subtracted and the pin is high for that cycle, otherwise it is low. With 0 < N < M any M consecutive output cycles hold exactly N high cycles.
- R8: In delta-sigma mode N = 0 keeps the pin low and N >= M (N not 0) keeps it high.
- R9: The two channels are independent: a write to one channel, or its mode, never changes the other channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared input clock for both channels |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| wrChan | input | 1 | Channel selected by a write |
| wrSel | input | 2 | Field selected by a write: 0 mode, 1 range, 2 data, 3 none |
| wrData | input | 16 | Value written |
| pwmOut | output | 2 | One output pin per channel, bit i for channel i |

## Verification
A wrong period counter or a shadow value loaded at the wrong moment shows up as a pulse edge moved by one or more cycles within the first period after a change, so a cycle-exact comparison catches it within M cycles. A corrupt accumulator in delta-sigma mode shows as a shifted or missing high cycle inside the next M-cycle window, and the count of highs per window then deviates from N. Leakage between channels or from ignored write fields shows on the other pin in the very next cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_PWM  = 2'd1,
    MODE_DSM  = 2'd2,
    MODE_RSV  = 2'd3
  } chanMode_t;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_RANGE = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } wrField_t;

  // strobes from a channel's control to its datapath
  typedef struct packed {
    logic clear;    // idle: zero state, pin low
    logic runPwm;   // advance counter-compare engine
    logic load;     // take new shadow values, restart period
    logic runDsm;   // advance delta-sigma engine
    logic dsmZero;  // N == 0
    logic dsmFull;  // N >= M, N != 0
  } chanCtl_t;

endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl #(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeVal,
  input  logic [W-1:0]       rangeVal,
  input  logic [W-1:0]       dataVal,
  input  logic               periodWrap,
  output pwm_pkg::chanCtl_t  ctl
);
  import pwm_pkg::*;

  chanMode_t mode;
  logic      wasPwm;

  assign mode = chanMode_t'(modeVal);

  always_comb begin
    ctl         = '0;
    ctl.clear   = (mode != MODE_PWM) && (mode != MODE_DSM);
    ctl.runPwm  = (mode == MODE_PWM);
    ctl.load    = (mode == MODE_PWM) && (!wasPwm || periodWrap);
    ctl.runDsm  = (mode == MODE_DSM);
    ctl.dsmZero = (dataVal == '0);
    ctl.dsmFull = (dataVal != '0) && (dataVal >= rangeVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wasPwm <= 1'b0;
    else       wasPwm <= (mode == MODE_PWM);
  end

endmodule

// File: rtl/pwm_chan_datapath.sv
module pwm_chan_datapath #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwm_pkg::chanCtl_t ctl,
  input  logic [W-1:0]      rangeVal,
  input  logic [W-1:0]      dataVal,
  output logic              periodWrap,
  output logic              pinOut
);

  logic [W-1:0] cnt;
  logic [W-1:0] shadowPer;
  logic [W-1:0] shadowRat;
  logic [W-1:0] acc;
  logic [W-1:0] cntInc;
  logic [W:0]   dsmSum;
  logic         dsmHit;
  logic [W-1:0] dsmRem;

  assign cntInc     = cnt + 1'b1;
  assign periodWrap = ({1'b0, cnt} + 1'b1) >= {1'b0, shadowPer};
  assign dsmSum     = {1'b0, acc} + {1'b0, dataVal};
  assign dsmHit     = dsmSum >= {1'b0, rangeVal};
  assign dsmRem     = acc + dataVal - rangeVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      shadowPer <= '0;
      shadowRat <= '0;
      acc       <= '0;
      pinOut    <= 1'b0;
    end else if (ctl.runPwm) begin
      acc <= '0;
      if (ctl.load) begin
        cnt       <= '0;
        shadowPer <= rangeVal;
        shadowRat <= dataVal;
        pinOut    <= (dataVal != '0);
      end else begin
        cnt    <= cntInc;
        pinOut <= (cntInc < shadowRat);
      end
    end else if (ctl.runDsm) begin
      cnt <= '0;
      if (ctl.dsmZero) begin
        acc    <= '0;
        pinOut <= 1'b0;
      end else if (ctl.dsmFull) begin
        acc    <= '0;
        pinOut <= 1'b1;
      end else if (dsmHit) begin
        acc    <= dsmRem;
        pinOut <= 1'b1;
      end else begin
        acc    <= dsmSum[W-1:0];
        pinOut <= 1'b0;
      end
    end else begin
      cnt    <= '0;
      acc    <= '0;
      pinOut <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_dual_ds.sv
module pwm_dual_ds #(
  parameter int W   = 16,
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [CW-1:0]  wrChan,
  input  logic [1:0]     wrSel,
  input  logic [W-1:0]   wrData,
  output logic [NCH-1:0] pwmOut
);
  import pwm_pkg::*;

  logic [NCH-1:0][1:0]   modeReg;
  logic [NCH-1:0][W-1:0] rangeReg;
  logic [NCH-1:0][W-1:0] dataReg;

  for (genvar g = 0; g < NCH; g++) begin : gChan
    chanCtl_t ctl;
    logic     wrap;
    logic     hit;

    assign hit = wrEn && (wrChan == CW'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeReg[g]  <= '0;
        rangeReg[g] <= '0;
        dataReg[g]  <= '0;
      end else if (hit) begin
        case (wrField_t'(wrSel))
          SEL_MODE:  modeReg[g]  <= wrData[1:0];
          SEL_RANGE: rangeReg[g] <= wrData;
          SEL_DATA:  dataReg[g]  <= wrData;
          default:   ;
        endcase
      end
    end

    pwm_chan_ctrl #(.W(W)) uCtrl (
      .clk       (clk),
      .rstN      (rstN),
      .modeVal   (modeReg[g]),
      .rangeVal  (rangeReg[g]),
      .dataVal   (dataReg[g]),
      .periodWrap(wrap),
      .ctl       (ctl)
    );

    pwm_chan_datapath #(.W(W)) uDp (
      .clk       (clk),
      .rstN      (rstN),
      .ctl       (ctl),
      .rangeVal  (rangeReg[g]),
      .dataVal   (dataReg[g]),
      .periodWrap(wrap),
      .pinOut    (pwmOut[g])
    );
  end

endmodule

// File: rtl/pwm_dual_ds_chk.sv
module pwm_dual_ds_chk #(
  parameter int W   = 16,
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [CW-1:0]         wrChan,
  input logic [1:0]            wrSel,
  input logic [W-1:0]          wrData,
  input logic [NCH-1:0][1:0]   modeReg,
  input logic [NCH-1:0][W-1:0] rangeReg,
  input logic [NCH-1:0][W-1:0] dataReg,
  input logic [NCH-1:0]        pwmOut
);

  for (genvar g = 0; g < NCH; g++) begin : gChk
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (modeReg[g] == 2'd0 || modeReg[g] == 2'd3) |=> !pwmOut[g]); // R3

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrChan == CW'(g) && wrSel == 2'd0) |=> modeReg[g] == $past(wrData[1:0])); // R2

    AST_DSM_FULL: assert property (@(posedge clk) disable iff (!rstN)
      (modeReg[g] == 2'd2 && dataReg[g] != '0 && dataReg[g] >= rangeReg[g]) |=> pwmOut[g]); // R8

    AST_DSM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (modeReg[g] == 2'd2 && dataReg[g] == '0) |=> !pwmOut[g]); // R8

    AST_OTHER_WRITE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrChan != CW'(g)) |=> $stable(modeReg[g])); // R9
  end

endmodule

bind pwm_dual_ds pwm_dual_ds_chk #(.W(W), .NCH(NCH)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrChan  (wrChan),
  .wrSel   (wrSel),
  .wrData  (wrData),
  .modeReg (modeReg),
  .rangeReg(rangeReg),
  .dataReg (dataReg),
  .pwmOut  (pwmOut)
);

// File: tb/test_pwm_dual_ds.sv
`timescale 1ns/1ps
module test_pwm_dual_ds;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [0:0]  wrChan = '0;
  logic [1:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  pwmOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_dual_ds i_pwm_dual_ds (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan),
    .wrSel(wrSel), .wrData(wrData), .pwmOut(pwmOut)
  );

  // behavioural reference state per channel
  int mMode[2], mRange[2], mData[2], mCnt[2], mPer[2], mRat[2], mAcc[2];
  bit mPrevPwm[2], mOut[2];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        mMode[c] = 0; mRange[c] = 0; mData[c] = 0; mCnt[c] = 0;
        mPer[c] = 0; mRat[c] = 0; mAcc[c] = 0; mPrevPwm[c] = 0; mOut[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (mMode[c] == 1) begin
          if (!mPrevPwm[c] || (mCnt[c] + 1 >= mPer[c])) begin
            mPer[c] = mRange[c]; mRat[c] = mData[c]; mCnt[c] = 0;
          end else mCnt[c] = mCnt[c] + 1;
          mAcc[c] = 0; mOut[c] = (mCnt[c] < mRat[c]); mPrevPwm[c] = 1;
        end else if (mMode[c] == 2) begin
          mCnt[c] = 0; mPrevPwm[c] = 0;
          if (mData[c] == 0) begin mAcc[c] = 0; mOut[c] = 0; end
          else if (mData[c] >= mRange[c]) begin mAcc[c] = 0; mOut[c] = 1; end
          else if (mAcc[c] + mData[c] >= mRange[c]) begin
            mAcc[c] = mAcc[c] + mData[c] - mRange[c]; mOut[c] = 1;
          end else begin
            mAcc[c] = mAcc[c] + mData[c]; mOut[c] = 0;
          end
        end else begin
          mCnt[c] = 0; mAcc[c] = 0; mOut[c] = 0; mPrevPwm[c] = 0;
        end
      end
      if (wrEn) begin
        case (wrSel)
          2'd0: mMode[wrChan]  = int'(wrData[1:0]);
          2'd1: mRange[wrChan] = int'(wrData);
          2'd2: mData[wrChan]  = int'(wrData);
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int c = 0; c < 2; c++) begin
        checks++;
        if (pwmOut[c] !== mOut[c]) begin
          fails++;
          $display("FAIL %s R9 ch%0d mode %0d: got %b expected %b at %0t",
                   (mMode[c] == 1) ? "R4 R6" : (mMode[c] == 2) ? "R7" : "R3",
                   c, mMode[c], pwmOut[c], mOut[c], $time);
        end
      end
    end
  end

  task automatic wr(input int ch, input int sel, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrChan = 1'(ch); wrSel = 2'(sel); wrData = 16'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectLevel(input int ch, input bit lvl, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (pwmOut[ch] !== lvl) begin
        fails++;
        $display("FAIL %s ch%0d: got %b expected %b", tag, ch, pwmOut[ch], lvl);
      end
    end
  endtask

  task automatic expectCount(input int ch, input int n, input int want, input string tag);
    int got = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut[ch]) got++;
    end
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s ch%0d: got %0d highs expected %0d", tag, ch, got, want);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (pwmOut !== 2'b00) begin
      fails++;
      $display("FAIL R1 reset: got %b expected 00", pwmOut);
    end
    rstN = 1'b1;
    expectLevel(0, 1'b0, 3, "R1");
    // R3: configured but idle stays low
    wr(0, 1, 10); wr(0, 2, 3);
    expectLevel(0, 1'b0, 4, "R3");
    // R4: PWM period 10, 3 high
    wr(0, 0, 1);
    repeat (5) @(negedge clk);
    expectCount(0, 10, 3, "R4");
    // R6: mid-period change, checked by reference comparison
    wr(0, 2, 7); wr(0, 1, 6);
    repeat (12) @(negedge clk);
    expectCount(0, 6, 6, "R6");
    // R7 with channel 0 still running (R9)
    wr(1, 1, 8); wr(1, 2, 3); wr(1, 0, 2);
    repeat (20) @(negedge clk);
    expectCount(1, 8, 3, "R7");
    expectCount(1, 8, 3, "R7");
    wr(1, 2, 5); wr(1, 1, 7);
    repeat (10) @(negedge clk);
    expectCount(1, 7, 5, "R7");
    // R5 on channel 0 (range 6)
    wr(0, 2, 20);
    repeat (10) @(negedge clk);
    expectLevel(0, 1'b1, 12, "R5");
    wr(0, 2, 0);
    repeat (10) @(negedge clk);
    expectLevel(0, 1'b0, 12, "R5");
    // R8 on channel 1
    wr(1, 2, 0);
    repeat (2) @(negedge clk);
    expectLevel(1, 1'b0, 10, "R8");
    wr(1, 2, 7);
    repeat (2) @(negedge clk);
    expectLevel(1, 1'b1, 10, "R8");
    // R2: field 3 is ignored; R9: writes to channel 0 leave channel 1 alone
    wr(1, 3, 0);
    expectLevel(1, 1'b1, 5, "R2");
    wr(0, 0, 0); wr(0, 1, 1); wr(0, 2, 0);
    expectLevel(1, 1'b1, 5, "R9");
    // R3: mode 3 is idle, then a fresh PWM start
    wr(0, 1, 5); wr(0, 2, 2); wr(0, 0, 3);
    expectLevel(0, 1'b0, 6, "R3");
    wr(0, 0, 1);
    repeat (7) @(negedge clk);
    expectCount(0, 5, 2, "R4");
    // switch channel 1 from delta-sigma to PWM and back
    wr(1, 2, 3); wr(1, 0, 1);
    repeat (30) @(negedge clk);
    wr(1, 0, 2);
    repeat (30) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule